// File: doc/BRIEF.md
# Card-Detect Interrupt Status Register

This block is a single 32-bit memory-mapped word that gathers the interrupt sources of a removable-card host controller. The controller's event sources each raise a one-cycle pulse: card inserted, card removed, transfer FIFO empty, DMA complete, FIFO underrun, FIFO length mismatch and DMA failure. Each pulse latches a sticky status bit in the lower half of the word. Every status bit has an enable bit placed 16 positions above it in the upper half. The block drives one level-sensitive interrupt line, which is high while any latched event has its enable set.

Software reads the whole word through a plain synchronous register port. To acknowledge an event it writes a 0 to that status bit. Writing a 1 leaves a status bit as it is, so a read-modify-write cannot lose an event that arrives at the same time. The same write also loads all seven enable bits.

Two further bits are read-only views of asynchronous inputs, the card-present level and the LED state. Each passes through a two-flop synchronizer, and no write can change either bit.

Top module: `cdirq_reg`

## Requirements
- R1: A synchronous active-high reset clears every status bit, every enable bit, the synchronizer flops and the interrupt output. While reset is applied, the word reads 0x00000000.
- R2: A one-cycle pulse on evt_pulse[i] sets status bit 8+i at the next clock edge. The bit order is: 8 inserted, 9 removed, 10 FIFO empty, 11 DMA done, 12 underrun, 13 length mismatch, 14 DMA error.
- R3: A status bit stays set through any write that carries a 1 in its position.
- R4: A write with a 0 in bit 8+i clears status bit i. If evt_pulse[i] is high in the same cycle, the bit is set instead (set wins).
- R5: Every write loads enable bit i, read back at bit 24+i, directly from write-data bit 24+i. Without a write, the enable bits hold.
- R6: irq is a register. After each clock edge it equals the OR over i of (status[i] AND enable[i]) as they stood before that edge, so it follows a status or enable change one cycle later.
- R7: Bit 1 reads the card-present input and bit 15 reads the LED input. Each input passes through two flops, so a change shows after the second clock edge. Writes never alter either bit.
- R8: Bits 0, 7:2, 23:16 and 31 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register word |
| bus_wdata | input | 32 | Write data: status acknowledge in 14:8, enables in 30:24 |
| bus_rdata | output | 32 | Current register word |
| evt_pulse | input | 7 | One-cycle event pulses, bit i sets status bit 8+i |
| card_present_in | input | 1 | Asynchronous card-present level |
| led_state_in | input | 1 | Asynchronous LED state level |
| irq | output | 1 | Registered level interrupt |

## Verification
An event pulse and a software write that acknowledges the same bit can land in the same clock cycle. The bench provokes this by driving evt_pulse together with a write that clears all seven status bits. The pulsed bits must read back set afterwards and the bits that were not pulsed must read back clear. It also sets one new event in the same cycle as a write that drops every enable. It then checks that irq still reports the old masked state for one cycle and falls in the cycle after.

// File: rtl/cdirq_pkg.sv
package cdirq_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_EVT   = 7;
    localparam int ST_LSB    = 8;
    localparam int EN_OFS    = 16;
    localparam int EN_LSB    = ST_LSB + EN_OFS;
    localparam int PRES_BIT  = 1;
    localparam int LED_BIT   = 15;
    localparam int SYNC_DEPTH = 2;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    // Decoded write request seen by the event bank.
    typedef struct packed {
        logic     wr;
        evt_vec_t keep;   // 1 = leave status bit alone, 0 = acknowledge
        evt_vec_t en;     // new enable values
    } wr_cmd_t;

    // Live register contents before packing into the word.
    typedef struct packed {
        evt_vec_t st;
        evt_vec_t en;
        logic     pres;
        logic     led;
    } reg_view_t;

    function automatic wr_cmd_t decode_write(input logic wr, input logic [REG_W-1:0] d);
        wr_cmd_t c;
        c.wr   = wr;
        c.keep = d[ST_LSB +: NUM_EVT];
        c.en   = d[EN_LSB +: NUM_EVT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input reg_view_t v);
        logic [REG_W-1:0] w;
        w = '0;
        w[ST_LSB +: NUM_EVT] = v.st;
        w[EN_LSB +: NUM_EVT] = v.en;
        w[PRES_BIT]          = v.pres;
        w[LED_BIT]           = v.led;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[ST_LSB +: NUM_EVT] = '1;
        m[EN_LSB +: NUM_EVT] = '1;
        return m;
    endfunction

endpackage

// File: rtl/cdirq_sync.sv
module cdirq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/cdirq_evt_bank.sv
module cdirq_evt_bank
    import cdirq_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic         wr,
    input  logic [N-1:0] wr_keep,
    input  logic [N-1:0] wr_en,
    output logic [N-1:0] st_q,
    output logic [N-1:0] en_q
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic ack;
        assign ack = wr & ~wr_keep[i];

        // Sticky status: a pulse sets it and takes priority over an acknowledge.
        always_ff @(posedge clk) begin
            if (rst)               st_q[i] <= 1'b0;
            else if (set_pulse[i]) st_q[i] <= 1'b1;
            else if (ack)          st_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)     en_q[i] <= 1'b0;
            else if (wr) en_q[i] <= wr_en[i];
        end
    end

endmodule

// File: rtl/cdirq_irq_out.sv
module cdirq_irq_out #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] st,
    input  logic [N-1:0] en,
    output logic         irq_q
);

    logic pending;
    assign pending = |(st & en);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pending;
    end

endmodule

// File: rtl/cdirq_reg.sv
module cdirq_reg
    import cdirq_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              card_present_in,
    input  logic              led_state_in,
    output logic              irq
);

    localparam logic [REG_W-1:0] USED = used_mask();

    wr_cmd_t   cmd;
    reg_view_t view;
    logic [1:0] lvl_sync;
    logic       wdata_unused;

    assign cmd = decode_write(bus_wr, bus_wdata);
    assign wdata_unused = ^(bus_wdata & ~USED);

    cdirq_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({led_state_in, card_present_in}),
        .q_sync  (lvl_sync)
    );

    cdirq_evt_bank #(.N(N_EVT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_pulse),
        .wr        (cmd.wr),
        .wr_keep   (cmd.keep),
        .wr_en     (cmd.en),
        .st_q      (view.st),
        .en_q      (view.en)
    );

    cdirq_irq_out #(.N(N_EVT)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .st    (view.st),
        .en    (view.en),
        .irq_q (irq)
    );

    assign view.pres = lvl_sync[0];
    assign view.led  = lvl_sync[1];

    assign bus_rdata = pack_word(view);

endmodule

// File: rtl/cdirq_reg_chk.sv
module cdirq_reg_chk
    import cdirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic              irq
);

    evt_vec_t st, en, wkeep;
    assign st    = bus_rdata[ST_LSB +: NUM_EVT];
    assign en    = bus_rdata[EN_LSB +: NUM_EVT];
    assign wkeep = bus_wdata[ST_LSB +: NUM_EVT];

    // R2: a pulse always leaves its status bit set
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        |evt_pulse |=> ((st & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: written ones never clear a status bit
    a_r3_one_keeps: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> ((~st & $past(st) & $past(wkeep)) == '0));

    // R4: a zero clears unless a pulse arrives together with it
    a_r4_zero_clears: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> ((st & ~$past(wkeep) & ~$past(evt_pulse)) == '0));

    // R2/R4: without a write or pulse status holds
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && evt_pulse == '0) |=> $stable(st));

    // R5: enables follow the write data
    a_r5_enable_load: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (en == $past(bus_wdata[EN_LSB +: NUM_EVT])));

    // R6: interrupt lags the masked status by one cycle
    a_r6_irq_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(st & en))));

    // R8: reserved bits stay zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~(used_mask() | (REG_W'(1) << PRES_BIT) | (REG_W'(1) << LED_BIT))) == '0);

endmodule

bind cdirq_reg cdirq_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
);

// File: tb/cdirq_reg_tb.sv
`timescale 1ns/1ps
module cdirq_reg_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_pulse;
    logic        card_present_in;
    logic        led_state_in;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cdirq_reg u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .card_present_in(card_present_in), .led_state_in(led_state_in), .irq(irq)
    );

    typedef struct packed {
        logic [6:0]  evt;
        logic        wr;
        logic [31:0] wdata;
        logic [6:0]  st;
        logic [6:0]  en;
        logic        irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{7'h01, 1'b0, 32'h0000_0000, 7'h01, 7'h00, 1'b0}, // R2 insert -> bit 8
        '{7'h00, 1'b1, 32'hFFFF_FFFF, 7'h01, 7'h7F, 1'b0}, // R3 R5 R8
        '{7'h00, 1'b0, 32'h0000_0000, 7'h01, 7'h7F, 1'b1}, // R6 irq one cycle late
        '{7'h00, 1'b1, 32'h7F00_7E00, 7'h00, 7'h7F, 1'b1}, // R4 clear bit 8
        '{7'h00, 1'b0, 32'h0000_0000, 7'h00, 7'h7F, 1'b0}, // R6 irq falls
        '{7'h24, 1'b1, 32'h7F00_0000, 7'h24, 7'h7F, 1'b0}, // R4 set wins over clear
        '{7'h40, 1'b1, 32'h0000_7F00, 7'h64, 7'h00, 1'b1}, // R5 enables off, R6 old state
        '{7'h00, 1'b0, 32'h0000_0000, 7'h64, 7'h00, 1'b0}, // R6 masked
        '{7'h00, 1'b1, 32'h0400_7F00, 7'h64, 7'h04, 1'b0}, // R5 single enable
        '{7'h00, 1'b0, 32'h0000_0000, 7'h64, 7'h04, 1'b1}, // R6 single source
        '{7'h00, 1'b1, 32'h0000_0000, 7'h00, 7'h00, 1'b1}, // R4 clear all
        '{7'h00, 1'b0, 32'h0000_0000, 7'h00, 7'h00, 1'b0}  // R6 idle
    };

    function automatic logic [31:0] word(input logic [6:0] st, input logic [6:0] en,
                                         input logic pres, input logic led);
        return {1'b0, en, 8'h00, led, st, 6'h00, pres, 1'b0};
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, return at the following negedge
    task automatic step(input logic [6:0] e, input logic w, input logic [31:0] d);
        evt_pulse = e; bus_wr = w; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        evt_pulse = '0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_wdata = '0; evt_pulse = '0;
        card_present_in = 1'b0; led_state_in = 1'b0;
        repeat (3) @(negedge clk);
        check32("R1 reset word", bus_rdata, 32'h0);
        check32("R1 reset irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].evt, VEC[k].wr, VEC[k].wdata);
            check32($sformatf("R2-table word step %0d", k), bus_rdata,
                    word(VEC[k].st, VEC[k].en, 1'b0, 1'b0));
            check32($sformatf("R6 irq step %0d", k), {31'h0, irq}, {31'h0, VEC[k].irq});
        end

        // R7: two-flop latency, status-only
        card_present_in = 1'b1; led_state_in = 1'b1;
        step(7'h00, 1'b0, 32'h0);
        check32("R7 first edge", bus_rdata, 32'h0);
        step(7'h00, 1'b1, 32'h0000_0000);
        check32("R7 second edge, write zero ignored", bus_rdata, word(7'h00, 7'h00, 1'b1, 1'b1));
        step(7'h00, 1'b1, 32'h0000_0000);
        check32("R7 still set after write", bus_rdata, word(7'h00, 7'h00, 1'b1, 1'b1));
        card_present_in = 1'b0;
        step(7'h00, 1'b0, 32'h0);
        check32("R7 removal first edge", bus_rdata[1], 1'b1);
        step(7'h00, 1'b0, 32'h0);
        check32("R7 removal second edge", bus_rdata, word(7'h00, 7'h00, 1'b0, 1'b1));

        // R8 with every bit written as one
        step(7'h7F, 1'b1, 32'hFFFF_FFFF);
        check32("R8 reserved zero", bus_rdata, word(7'h7F, 7'h7F, 1'b0, 1'b1));
        step(7'h00, 1'b0, 32'h0);
        check32("R6 all sources", {31'h0, irq}, 32'h1);

        // R1: reset mid-operation
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check32("R1 reset clears word", bus_rdata, 32'h0);
        check32("R1 reset clears irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule